// File: doc/BRIEF.md
# Sinc-Cubed Sample-Rate Interpolator

This block raises a stream of 16-bit two's-complement audio samples from a programmable input rate to a fixed output rate. Both rates come from one master clock: an input tick every N clock cycles and an output tick every 8 clock cycles. The interpolation ratio is R = N/8. Between the two rates sits a third-order comb/integrator structure whose response is the cube of (1 - z^-R)/(1 - z^-1). Three comb stages run at the input rate, zeros are stuffed between input samples, and three integrators run at the output rate. The output drives a downstream noise-shaping modulator, which cannot stall.

The host writes samples into a holding register whenever it likes. At each input tick the block takes whatever the register holds, so a host that misses a period causes the previous sample to be used again. A bypass control removes the filter for minimum group delay: at each output tick the held sample goes straight to the output. A change of the ratio select or of the bypass control clears all filter state and restarts the rate counter.

Input handshake: `in_ready` is always high, and every beat with `in_valid` high is accepted and overwrites the held sample. Output handshake: there is no ready. `out_valid` is a one-cycle strobe, and the consumer must take `out_data` in that cycle.

Top module: `cic_interp_x3`

## Requirements
- R1: `out_valid` is high for exactly one cycle in every 8, with 7 low cycles between pulses, while the configuration is unchanged.
- R2: `rate_sel` values 0, 1, 2 and 3 select N = 32, 64, 128 and 256 (R = 4, 8, 16, 32). One input tick occurs every N cycles, and it coincides with an output tick.
- R3: A constant input x settles to an output of exactly x for every ratio. The filter's DC gain of R^2 is removed by an arithmetic right shift of 2*log2(R), and the internal words never overflow.
- R4: Every output matches, bit for bit, the sinc-cubed filter applied to the zero-stuffed sequence of held samples. The shift rounds toward minus infinity.
- R5: When the host writes nothing, each input tick reuses the last held sample, so a settled output stays constant.
- R6: With `bypass` high, each `out_valid` presents the sample held in the register in the cycle before the strobe.
- R7: A change of `rate_sel` or `bypass` suppresses `out_valid` for one cycle and clears the comb and integrator state. The next cycle is an input tick, and its output is x >>> 2*log2(R), where x is the held sample.
- R8: Full-scale inputs 0x7FFF and 0x8000 come out exactly at full scale. Any result outside the 16-bit range is clamped to 0x7FFF or 0x8000.
- R9: `in_ready` is always 1. Of several writes within one input period, only the last one is used.
- R10: While reset is asserted and just after it, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Ratio select: N = 32 << rate_sel |
| bypass | input | 1 | Skip the filter and present the held sample directly |
| in_valid | input | 1 | Host sample strobe |
| in_ready | output | 1 | Always 1; the block never refuses a sample |
| in_data | input | 16 | Host sample, two's complement |
| out_valid | output | 1 | One-cycle strobe every 8 cycles |
| out_data | output | 16 | Interpolated sample, two's complement |

## Verification
A behavioural integer model is compared with the design on every clock. It is driven through DC steps at all four ratios, a varying sequence with skipped writes, full-scale steps and bypass periods. A shift derived from R^3 instead of R^2 would leave the settled DC output 1/R too small. A zero that is not stuffed, or an integrator clocked at the input rate, breaks the bit-exact match right after each step. State that survives a configuration change shows up as a first output other than x >>> 2*log2(R). A held register that is cleared, or that keeps the first of two writes, shows up in the repetition and last-write checks.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int DW        = 16;  // sample word width
  localparam int SEL_W     = 2;   // ratio select width
  localparam int STAGES    = 3;   // filter order
  localparam int PH_W      = 3;   // output tick every 2**PH_W cycles
  localparam int LOG2R_MIN = 2;   // smallest ratio R = 4
  localparam int LOG2R_MAX = LOG2R_MIN + (1 << SEL_W) - 1;
  localparam int AW        = DW + STAGES * LOG2R_MAX;
  localparam int CNT_W     = PH_W + LOG2R_MAX;
endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl #(
  parameter int SEL_W     = cic_pkg::SEL_W,
  parameter int PH_W      = cic_pkg::PH_W,
  parameter int LOG2R_MIN = cic_pkg::LOG2R_MIN,
  parameter int CNT_W     = cic_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             bypass,
  output logic [SEL_W-1:0] rsel_q,
  output logic             byp_q,
  output logic             cfg_chg,
  output logic             in_tick,
  output logic             out_tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign cfg_chg  = (rate_sel != rsel_q) || (bypass != byp_q);
  assign lim      = CNT_W'((1 << (PH_W + LOG2R_MIN + int'(rsel_q))) - 1);
  assign in_tick  = !cfg_chg && (cnt == '0);
  assign out_tick = !cfg_chg && (cnt[PH_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rsel_q <= '0;
      byp_q  <= 1'b0;
    end else if (cfg_chg) begin
      cnt    <= '0;
      rsel_q <= rate_sel;
      byp_q  <= bypass;
    end else begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

  // R2: an input tick is also an output tick, and ticks never come back to back
  a_r2_tick_align: assert property (@(posedge clk) disable iff (!rst_n)
    in_tick |-> out_tick);
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    in_tick |=> !in_tick);
endmodule

// File: rtl/cic_comb_sect.sv
module cic_comb_sect #(
  parameter int DW     = cic_pkg::DW,
  parameter int AW     = cic_pkg::AW,
  parameter int STAGES = cic_pkg::STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [DW-1:0]        x,
  output logic signed [AW-1:0] y
);
  logic signed [AW-1:0] stg [STAGES+1];
  logic signed [AW-1:0] dly [STAGES];

  assign stg[0] = {{(AW-DW){x[DW-1]}}, x};

  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    assign stg[g+1] = stg[g] - dly[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dly[g] <= '0;
      else if (clr) dly[g] <= '0;
      else if (en)  dly[g] <= stg[g];
    end
  end

  assign y = stg[STAGES];
endmodule

// File: rtl/cic_integ_sect.sv
module cic_integ_sect #(
  parameter int AW     = cic_pkg::AW,
  parameter int STAGES = cic_pkg::STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [AW-1:0] u,
  output logic signed [AW-1:0] sum_nxt
);
  logic signed [AW-1:0] nxt [STAGES+1];
  logic signed [AW-1:0] acc [STAGES];

  assign nxt[0] = u;

  for (genvar g = 0; g < STAGES; g++) begin : g_integ
    assign nxt[g+1] = acc[g] + nxt[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc[g] <= '0;
      else if (clr) acc[g] <= '0;
      else if (en)  acc[g] <= nxt[g+1];
    end
  end

  assign sum_nxt = nxt[STAGES];
endmodule

// File: rtl/cic_interp_x3.sv
module cic_interp_x3 #(
  parameter int DW        = cic_pkg::DW,
  parameter int SEL_W     = cic_pkg::SEL_W,
  parameter int STAGES    = cic_pkg::STAGES,
  parameter int PH_W      = cic_pkg::PH_W,
  parameter int LOG2R_MIN = cic_pkg::LOG2R_MIN,
  parameter int AW        = cic_pkg::AW,
  parameter int CNT_W     = cic_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             bypass,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  output logic [DW-1:0]    out_data
);
  localparam int SH_W = $clog2(2 * (LOG2R_MIN + (1 << SEL_W))) + 1;

  logic [SEL_W-1:0]     rsel_q;
  logic                 byp_q, cfg_chg, in_tick, out_tick;
  logic [DW-1:0]        hold_q;
  logic signed [AW-1:0] comb_y, stuffed, integ_sum, shifted;
  logic [SH_W-1:0]      shamt;
  logic [DW-1:0]        sat_y;

  assign in_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (in_valid) hold_q <= in_data;
  end

  cic_rate_ctrl #(.SEL_W(SEL_W), .PH_W(PH_W), .LOG2R_MIN(LOG2R_MIN), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bypass(bypass),
    .rsel_q(rsel_q), .byp_q(byp_q), .cfg_chg(cfg_chg),
    .in_tick(in_tick), .out_tick(out_tick));

  cic_comb_sect #(.DW(DW), .AW(AW), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .en(in_tick && !byp_q),
    .x(hold_q), .y(comb_y));

  assign stuffed = in_tick ? comb_y : '0;

  cic_integ_sect #(.AW(AW), .STAGES(STAGES)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .en(out_tick && !byp_q),
    .u(stuffed), .sum_nxt(integ_sum));

  // DC gain of a zero-stuffed cube-sinc is R^2; remove it with a shift
  assign shamt   = SH_W'(2 * (LOG2R_MIN + int'(rsel_q)));
  assign shifted = integ_sum >>> shamt;

  always_comb begin
    if (&shifted[AW-1:DW-1] || ~|shifted[AW-1:DW-1])
      sat_y = shifted[DW-1:0];
    else if (shifted[AW-1])
      sat_y = {1'b1, {(DW-1){1'b0}}};
    else
      sat_y = {1'b0, {(DW-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (cfg_chg) begin
      out_valid <= 1'b0;
    end else if (out_tick) begin
      out_valid <= 1'b1;
      out_data  <= byp_q ? hold_q : sat_y;
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R1: a strobe is never followed by another in the next cycle
  a_r1_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7: a configuration change suppresses the next strobe
  a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !out_valid);
  // R6: in bypass the strobe carries the held sample
  a_r6_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick && byp_q |=> out_valid && out_data == $past(hold_q));
  // R3: the scaled integrator sum always fits the sample word
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick && !byp_q |-> (&shifted[AW-1:DW-1] || ~|shifted[AW-1:DW-1]));
endmodule

// File: tb/tb_cic_interp_x3.sv
`timescale 1ns/1ps
module tb_cic_interp_x3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic        bypass = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = 16'd0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  int ntests = 0, nfails = 0;
  bit done = 1'b0;
  string cur_req = "R4";

  always #5 clk = ~clk;

  cic_interp_x3 dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bypass(bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  // behavioural reference model
  int     m_cnt, m_hold, m_sel;
  bit     m_byp, e_valid;
  logic [15:0] e_data;
  longint md[3], ma[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_sel = 0; m_byp = 0; e_valid = 0; e_data = 0;
      for (int k = 0; k < 3; k++) begin md[k] = 0; ma[k] = 0; end
    end else begin
      if (int'(rate_sel) != m_sel || bypass != m_byp) begin
        m_sel = int'(rate_sel); m_byp = bypass; m_cnt = 0; e_valid = 0;
        for (int k = 0; k < 3; k++) begin md[k] = 0; ma[k] = 0; end
      end else begin
        int lr, nn;
        lr = 2 + m_sel;
        nn = 1 << (3 + lr);
        if (m_cnt % 8 == 0) begin
          e_valid = 1;
          if (m_byp) e_data = 16'(m_hold);
          else begin
            longint u, c, t, y;
            u = 0;
            if (m_cnt == 0) begin
              c = m_hold;
              for (int k = 0; k < 3; k++) begin t = c - md[k]; md[k] = c; c = t; end
              u = c;
            end
            ma[0] += u; ma[1] += ma[0]; ma[2] += ma[1];
            y = ma[2] >>> (2 * lr);
            if (y > 32767) y = 32767;
            if (y < -32768) y = -32768;
            e_data = 16'(y);
          end
        end else e_valid = 0;
        m_cnt = (m_cnt == nn - 1) ? 0 : m_cnt + 1;
      end
      if (in_valid) m_hold = int'($signed(in_data));
    end
  end

  // compare with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      ntests++;
      if (out_valid !== e_valid || (e_valid && out_data !== e_data)) begin
        nfails++;
        $display("FAIL %s model compare: valid=%0b data=%h expected valid=%0b data=%h",
                 cur_req, out_valid, out_data, e_valid, e_data);
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    ntests++;
    if (act !== exp) begin
      nfails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(logic [15:0] v);
    in_valid = 1'b1; in_data = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_valid();
    while (!out_valid) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      nfails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", ntests, nfails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    cyc(3);
    check("R10 valid in reset", {15'd0, out_valid}, 16'd0);
    check("R10 data in reset", out_data, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 data after reset", out_data, 16'd0);
    check("R9 in_ready", {15'd0, in_ready}, 16'd1);

    // R3 / R2: DC step for every ratio
    for (int s = 0; s < 4; s++) begin
      logic [15:0] x;
      int n;
      x = (s % 2 == 1) ? 16'(-12345 + s) : 16'(2047 + 1000 * s);
      n = 32 << s;
      cur_req = "R2";
      rate_sel = 2'(s);
      put(x);
      cyc(4 * n + 8);
      wait_valid();
      check($sformatf("R3 DC settle sel=%0d", s), out_data, x);
      // R1: pulse spacing
      begin
        int gap;
        gap = 0;
        do begin @(negedge clk); gap++; end while (!out_valid);
        check($sformatf("R1 spacing sel=%0d", s), 16'(gap), 16'd8);
      end
    end

    // R7: ratio change clears state; first output is x >>> 2*log2(R)
    cur_req = "R7";
    rate_sel = 2'd3;
    put(16'd16000);
    cyc(300);
    rate_sel = 2'd0;
    @(negedge clk);
    check("R7 strobe dropped on change", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check("R7 strobe after clear", {15'd0, out_valid}, 16'd1);
    check("R7 first output after clear", out_data, 16'd1000);

    // R4: varying samples with skipped writes, bit-exact vs model
    cur_req = "R4";
    rate_sel = 2'd1;
    for (int i = 0; i < 24; i++) begin
      if (i % 5 != 3) put(16'(i * 3301 - 30000));
      else @(negedge clk);
      cyc(63);
    end

    // R5: no writes, output repeats the settled value
    cur_req = "R5";
    put(16'd777);
    cyc(64 * 5);
    cyc(64 * 6);
    wait_valid();
    check("R5 repetition without writes", out_data, 16'd777);

    // R9: two writes in one period, the last one wins
    cur_req = "R9";
    put(16'd100);
    put(16'd5555);
    cyc(64 * 5);
    wait_valid();
    check("R9 last write used", out_data, 16'd5555);

    // R8: full-scale steps
    cur_req = "R8";
    rate_sel = 2'd2;
    put(16'h7FFF);
    cyc(128 * 5);
    wait_valid();
    check("R8 positive full scale", out_data, 16'h7FFF);
    put(16'h8000);
    cyc(128 * 5);
    wait_valid();
    check("R8 negative full scale", out_data, 16'h8000);

    // R6: bypass presents the held sample at the next strobe
    cur_req = "R6";
    bypass = 1'b1;
    put(16'h1234);
    wait_valid();
    check("R6 bypass sample", out_data, 16'h1234);
    @(negedge clk);
    put(16'hBEEF);
    wait_valid();
    check("R6 bypass follows new sample", out_data, 16'hBEEF);
    @(negedge clk);
    cyc(8);
    wait_valid();
    check("R6 bypass repeats held", out_data, 16'hBEEF);
    bypass = 1'b0;
    cur_req = "R7";
    @(negedge clk);
    check("R7 strobe dropped on bypass exit", {15'd0, out_valid}, 16'd0);
    cyc(600);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfails);
    $finish;
  end
endmodule